// File: doc/BRIEF.md
# Byte-Wide Host Parallel Port

This block lets an external host CPU or DMA engine pass 16-bit words to and from an on-chip processor over an 8-bit bidirectional bus. The host side is asynchronous. It has an active-low chip select, active-low read and write strobes, and a two-bit address. Address bit 0 selects the low or high byte. Address bit 1 selects the data path or the status register. The processor side is a simple register bus with read and write enables, a two-bit register address, 16-bit data, a wait output and an interrupt output.

Each host strobe is synchronized to the system clock. An access takes effect once, when the strobe is released. The host must hold the address and write data stable for one clock period after release. Inbound words are built from two bytes, and the word is handed over when the high byte arrives. Outbound words are drained by the host, and the word is released when the high byte is read. An input-full flag and an output-full flag are visible to both sides. A dedicated ready pin tells the host whether it may write a new word. The processor may poll the status register. It may also let the wait output stall an access that cannot complete yet. A third option is to enable an interrupt on either handshake event.

State machines. The inbound channel has states IN_EMPTY, IN_HALF and IN_FULL. Its transitions are:
- IN_EMPTY to IN_HALF on a low-byte write.
- IN_EMPTY or IN_HALF to IN_FULL on a high-byte write.
- IN_HALF to IN_HALF on a repeated low-byte write.
- IN_FULL to IN_EMPTY on a processor word read.

The outbound channel has states OUT_EMPTY and OUT_FULL. Its transitions are:
- OUT_EMPTY to OUT_FULL on a processor word write.
- OUT_FULL to OUT_EMPTY on a host high-byte read.

Top module: `hpi_bridge`

## Requirements
- R1: After reset the status register reads 0, `host_rdy` is 1 and `p_irq` is 0.
- R2: A host write to address 0 stores the low byte and a write to address 1 stores the high byte. The word {high, low} becomes readable to the processor, and input-full (status bit 0) sets, only after the high-byte write. A low-byte write alone leaves input-full at 0.
- R3: A processor read of register 0 returns the inbound word and clears input-full. `host_rdy` is 0 while input-full is set and 1 otherwise.
- R4: Host writes to addresses 0 and 1 while input-full is set are ignored, and the held word is unchanged.
- R5: A processor write to register 1 loads the outbound word and sets output-full (status bit 1). A host read of address 0 returns bits 7:0 and has no other effect. A host read of address 1 returns bits 15:8 and clears output-full.
- R6: `p_wait` is 1 when the processor reads register 0 while input-full is clear, or writes register 1 while output-full is set. A stalled access changes no state.
- R7: Status bits are input-full (bit 0), output-full (bit 1), input interrupt enable (bit 2) and output interrupt enable (bit 3), and all other bits read 0. The processor reads the status at register 2 and can write only bits 3:2. The host reads the status low byte at address 2 and a zero high byte at address 3. Host writes to addresses 2 and 3 are ignored.
- R8: `p_irq` pulses for one cycle when input-full sets with bit 2 enabled, or when output-full clears with bit 3 enabled. No pulse occurs when the matching enable is off.
- R9: The interrupt decision uses the enable value held before the clock edge. A status write that sets bit 2 in the same cycle as input-full sets produces no pulse.
- R10: A host access takes effect once, only after its strobe is released, however long the strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_cs_n | input | 1 | Host chip select, active low |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_addr | input | 2 | Host address: bit 0 byte, bit 1 register |
| h_din | input | 8 | Host write data |
| h_dout | output | 8 | Host read data |
| h_doe | output | 1 | Drive enable for the host data bus |
| host_rdy | output | 1 | High when the host may write a new word |
| p_rd | input | 1 | Processor read enable |
| p_wr | input | 1 | Processor write enable |
| p_addr | input | 2 | Processor register: 0 inbound, 1 outbound, 2 status |
| p_wdata | input | 16 | Processor write data |
| p_rdata | output | 16 | Processor read data |
| p_wait | output | 1 | Stall request for the current processor access |
| p_irq | output | 1 | One-cycle interrupt pulse |

## Verification
Two functions can fall in the same clock edge: a processor write that changes the interrupt enables, and a synchronized host high-byte write that sets input-full. The bench releases the host write strobe and counts the synchronizer stages. It then places the status write so that its edge is exactly the edge at which input-full sets. The bench judges the outcome in two ways. First, no interrupt pulse may appear. Second, a later status read must show both the new enable and input-full set.

// File: rtl/hpi_pkg.sv
`timescale 1ns/1ps
package hpi_pkg;
    typedef enum logic [1:0] {IN_EMPTY, IN_HALF, IN_FULL} in_state_e;
    typedef enum logic {OUT_EMPTY, OUT_FULL} out_state_e;

    localparam int ST_IN_FULL  = 0;
    localparam int ST_OUT_FULL = 1;
    localparam int ST_IE_IN    = 2;
    localparam int ST_IE_OUT   = 3;

    localparam logic [1:0] PA_IN   = 2'd0;
    localparam logic [1:0] PA_OUT  = 2'd1;
    localparam logic [1:0] PA_STAT = 2'd2;

    localparam logic [1:0] HA_DATA_LO = 2'd0;
    localparam logic [1:0] HA_DATA_HI = 2'd1;
    localparam logic [1:0] HA_STAT_LO = 2'd2;
    localparam logic [1:0] HA_STAT_HI = 2'd3;
endpackage

// File: rtl/hpi_strobe_sync.sv
`timescale 1ns/1ps
module hpi_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic early,
    output logic done
);
    logic [STAGES:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-1:0], active};
    end

    assign early = sr[0];
    assign done  = sr[STAGES] & ~sr[STAGES-1];

    // R10: a release yields one completion pulse only
    a_r10_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/hpi_in_chan.sv
`timescale 1ns/1ps
module hpi_in_chan
    import hpi_pkg::*;
#(
    parameter int BW = 8,
    localparam int WW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] byte_in,
    input  logic          take,
    output logic [WW-1:0] word,
    output logic          full,
    output logic          set_pulse
);
    in_state_e     state, state_nx;
    logic [BW-1:0] lo_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= IN_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IN_EMPTY: if (wr_hi) state_nx = IN_FULL;
                      else if (wr_lo) state_nx = IN_HALF;
            IN_HALF:  if (wr_hi) state_nx = IN_FULL;
            IN_FULL:  if (take) state_nx = IN_EMPTY;
            default:  state_nx = IN_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_hold <= '0;
            word    <= '0;
        end else if (state != IN_FULL) begin
            if (wr_lo) lo_hold <= byte_in;
            if (wr_hi) word    <= {byte_in, lo_hold};
        end
    end

    assign full      = (state == IN_FULL);
    assign set_pulse = (state != IN_FULL) && wr_hi;

    // R4: a held word survives anything but a processor read
    a_r4_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !take) |=> (full && $stable(word)));
    // R2: the full flag rises only after a high-byte write
    a_r2_full_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(wr_hi));
endmodule

// File: rtl/hpi_out_chan.sv
`timescale 1ns/1ps
module hpi_out_chan
    import hpi_pkg::*;
#(
    parameter int BW = 8,
    localparam int WW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [WW-1:0] word_in,
    input  logic          rd_hi,
    output logic [WW-1:0] word,
    output logic          full,
    output logic          clr_pulse
);
    out_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OUT_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OUT_EMPTY: if (load)  state_nx = OUT_FULL;
            OUT_FULL:  if (rd_hi) state_nx = OUT_EMPTY;
            default:   state_nx = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          word <= '0;
        else if (state == OUT_EMPTY && load) word <= word_in;
    end

    assign full      = (state == OUT_FULL);
    assign clr_pulse = (state == OUT_FULL) && rd_hi;

    // R5: output-full drops only after a host high-byte read
    a_r5_clear_on_hi_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full) |-> $past(rd_hi));
    // R6: a pending word cannot be overwritten
    a_r6_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_hi) |=> (full && $stable(word)));
endmodule

// File: rtl/hpi_bridge.sv
`timescale 1ns/1ps
module hpi_bridge
    import hpi_pkg::*;
#(
    parameter int BW          = 8,
    parameter int SYNC_STAGES = 2,
    localparam int WW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_cs_n,
    input  logic          h_rd_n,
    input  logic          h_wr_n,
    input  logic [1:0]    h_addr,
    input  logic [BW-1:0] h_din,
    output logic [BW-1:0] h_dout,
    output logic          h_doe,
    output logic          host_rdy,
    input  logic          p_rd,
    input  logic          p_wr,
    input  logic [1:0]    p_addr,
    input  logic [WW-1:0] p_wdata,
    output logic [WW-1:0] p_rdata,
    output logic          p_wait,
    output logic          p_irq
);
    logic          rd_early, rd_done, wr_early, wr_done;
    logic [1:0]    addr_q;
    logic [BW-1:0] din_q;
    logic          in_full, out_full, in_set, out_clr;
    logic [WW-1:0] in_word, out_word, status;
    logic          ie_in, ie_out;
    logic          rd_in_req, wr_out_req, take, load;
    logic          wr_lo, wr_hi, rd_hi;

    hpi_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .active(~h_cs_n & ~h_rd_n),
        .early(rd_early), .done(rd_done));

    hpi_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .active(~h_cs_n & ~h_wr_n),
        .early(wr_early), .done(wr_done));

    // capture address and data while a synchronized strobe is seen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            din_q  <= '0;
        end else if (rd_early || wr_early) begin
            addr_q <= h_addr;
            din_q  <= h_din;
        end
    end

    assign wr_lo = wr_done && (addr_q == HA_DATA_LO);
    assign wr_hi = wr_done && (addr_q == HA_DATA_HI);
    assign rd_hi = rd_done && (addr_q == HA_DATA_HI);

    assign rd_in_req  = p_rd && (p_addr == PA_IN);
    assign wr_out_req = p_wr && !p_rd && (p_addr == PA_OUT);
    assign take       = rd_in_req && in_full;
    assign load       = wr_out_req && !out_full;
    assign p_wait     = (rd_in_req && !in_full) || (wr_out_req && out_full);

    hpi_in_chan #(.BW(BW)) u_in (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .byte_in(din_q), .take(take), .word(in_word),
        .full(in_full), .set_pulse(in_set));

    hpi_out_chan #(.BW(BW)) u_out (
        .clk(clk), .rst_n(rst_n), .load(load), .word_in(p_wdata),
        .rd_hi(rd_hi), .word(out_word), .full(out_full),
        .clr_pulse(out_clr));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_in  <= 1'b0;
            ie_out <= 1'b0;
            p_irq  <= 1'b0;
        end else begin
            p_irq <= (in_set && ie_in) || (out_clr && ie_out);
            if (p_wr && !p_rd && p_addr == PA_STAT) begin
                ie_in  <= p_wdata[ST_IE_IN];
                ie_out <= p_wdata[ST_IE_OUT];
            end
        end
    end

    always_comb begin
        status              = '0;
        status[ST_IN_FULL]  = in_full;
        status[ST_OUT_FULL] = out_full;
        status[ST_IE_IN]    = ie_in;
        status[ST_IE_OUT]   = ie_out;
    end

    always_comb begin
        unique case (p_addr)
            PA_IN:   p_rdata = in_word;
            PA_STAT: p_rdata = status;
            default: p_rdata = '0;
        endcase
    end

    always_comb begin
        unique case (h_addr)
            HA_DATA_LO: h_dout = out_word[BW-1:0];
            HA_DATA_HI: h_dout = out_word[WW-1:BW];
            HA_STAT_LO: h_dout = status[BW-1:0];
            default:    h_dout = status[WW-1:BW];
        endcase
    end

    assign h_doe    = ~h_cs_n & ~h_rd_n;
    assign host_rdy = ~in_full;

    // R8: every pulse has an enabled handshake event behind it
    a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        p_irq |-> (($rose(in_full) && $past(ie_in)) ||
                   ($fell(out_full) && $past(ie_out))));
    // R6: a stalled inbound read leaves input-full untouched
    a_r6_stall_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (p_wait && rd_in_req && !wr_hi) |=> !in_full);
endmodule

// File: tb/tb_hpi_bridge.sv
`timescale 1ns/1ps
module tb_hpi_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_cs_n = 1'b1, h_rd_n = 1'b1, h_wr_n = 1'b1;
    logic [1:0]  h_addr = '0;
    logic [7:0]  h_din = '0;
    logic [7:0]  h_dout;
    logic        h_doe, host_rdy;
    logic        p_rd = 1'b0, p_wr = 1'b0;
    logic [1:0]  p_addr = '0;
    logic [15:0] p_wdata = '0;
    logic [15:0] p_rdata;
    logic        p_wait, p_irq;

    always #2 clk = ~clk;

    hpi_bridge dut (
        .clk(clk), .rst_n(rst_n), .h_cs_n(h_cs_n), .h_rd_n(h_rd_n),
        .h_wr_n(h_wr_n), .h_addr(h_addr), .h_din(h_din), .h_dout(h_dout),
        .h_doe(h_doe), .host_rdy(host_rdy), .p_rd(p_rd), .p_wr(p_wr),
        .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
        .p_wait(p_wait), .p_irq(p_irq));

    int n_cmp = 0, n_bad = 0, irq_cnt = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        finished = 1'b0;

    always @(negedge clk) if (rst_n && p_irq) irq_cnt++;

    task automatic expect_val(input string tag, input logic [15:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // monitor side: pops the oldest expectation and compares
    task automatic observe(input logic [15:0] act);
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", t, act, e);
        end
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] e);
        expect_val(tag, e);
        observe(act);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        h_addr = a; h_din = d; h_cs_n = 1'b0; h_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        h_wr_n = 1'b1; h_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read(input logic [1:0] a, input int hold, output logic [7:0] d);
        @(negedge clk);
        h_addr = a; h_cs_n = 1'b0; h_rd_n = 1'b0;
        repeat (hold) @(negedge clk);
        d = h_dout;
        h_rd_n = 1'b1; h_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic proc_read(input logic [1:0] a, output logic [15:0] d, output logic w);
        @(negedge clk);
        p_addr = a; p_rd = 1'b1;
        #1;
        d = p_rdata; w = p_wait;
        @(negedge clk);
        p_rd = 1'b0;
    endtask

    task automatic proc_write(input logic [1:0] a, input logic [15:0] d, output logic w);
        @(negedge clk);
        p_addr = a; p_wdata = d; p_wr = 1'b1;
        #1;
        w = p_wait;
        @(negedge clk);
        p_wr = 1'b0;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  b;
        logic        w;
        int          base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        proc_read(2'd2, d, w);
        check("R1 status", d, 16'h0000);
        check("R1 host_rdy", {15'd0, host_rdy}, 16'd1);
        check("R1 irq count", irq_cnt[15:0], 16'd0);

        // R2 byte sequencing
        host_write(2'd0, 8'h34);
        proc_read(2'd2, d, w);
        check("R2 no full after low byte", d, 16'h0000);
        host_write(2'd1, 8'h12);
        proc_read(2'd2, d, w);
        check("R2 full after high byte", d, 16'h0001);
        check("R3 host_rdy low while full", {15'd0, host_rdy}, 16'd0);

        // R4 writes while full ignored
        host_write(2'd0, 8'hFF);
        host_write(2'd1, 8'hEE);
        proc_read(2'd0, d, w);
        check("R3 R4 inbound word", d, 16'h1234);
        proc_read(2'd2, d, w);
        check("R3 full cleared by read", d, 16'h0000);
        check("R3 host_rdy back high", {15'd0, host_rdy}, 16'd1);

        // R6 stalled read when empty
        proc_read(2'd0, d, w);
        check("R6 wait on empty read", {15'd0, w}, 16'd1);
        proc_read(2'd2, d, w);
        check("R6 stalled read no change", d, 16'h0000);

        // R5 outbound transfer
        proc_write(2'd1, 16'hABCD, w);
        check("R5 no wait on load", {15'd0, w}, 16'd0);
        host_read(2'd2, 3, b);
        check("R7 host status low byte", {8'd0, b}, 16'h0002);
        host_read(2'd0, 3, b);
        check("R5 low byte", {8'd0, b}, 16'h00CD);
        host_read(2'd2, 3, b);
        check("R5 low read keeps full", {8'd0, b}, 16'h0002);
        host_read(2'd1, 3, b);
        check("R5 high byte", {8'd0, b}, 16'h00AB);
        host_read(2'd2, 3, b);
        check("R5 high read clears full", {8'd0, b}, 16'h0000);

        // R6 stalled write when full
        proc_write(2'd1, 16'h5A5A, w);
        proc_write(2'd1, 16'h1111, w);
        check("R6 wait on full write", {15'd0, w}, 16'd1);
        host_read(2'd0, 3, b);
        check("R6 word not replaced", {8'd0, b}, 16'h005A);
        host_read(2'd1, 3, b);

        // R7 status access rules
        proc_write(2'd2, 16'hFFFF, w);
        proc_read(2'd2, d, w);
        check("R7 only enables writable", d, 16'h000C);
        host_write(2'd2, 8'h00);
        host_write(2'd3, 8'h00);
        proc_read(2'd2, d, w);
        check("R7 host status write ignored", d, 16'h000C);
        host_read(2'd3, 3, b);
        check("R7 status high byte zero", {8'd0, b}, 16'h0000);

        // R8 interrupts enabled
        base = irq_cnt;
        host_write(2'd0, 8'h01);
        host_write(2'd1, 8'h02);
        check("R8 irq on input full", 16'(irq_cnt - base), 16'd1);
        proc_read(2'd0, d, w);
        proc_write(2'd1, 16'h0303, w);
        host_read(2'd1, 3, b);
        check("R8 irq on output drained", 16'(irq_cnt - base), 16'd2);
        // R8 interrupts disabled
        proc_write(2'd2, 16'h0000, w);
        base = irq_cnt;
        host_write(2'd0, 8'h05);
        host_write(2'd1, 8'h06);
        proc_read(2'd0, d, w);
        proc_write(2'd1, 16'h0707, w);
        host_read(2'd1, 3, b);
        check("R8 no irq when disabled", 16'(irq_cnt - base), 16'd0);

        // R9 enable written on the edge where input-full sets
        host_write(2'd0, 8'h77);
        base = irq_cnt;
        @(negedge clk);
        h_addr = 2'd1; h_din = 8'h66; h_cs_n = 1'b0; h_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        h_wr_n = 1'b1; h_cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        p_addr = 2'd2; p_wdata = 16'h0004; p_wr = 1'b1;
        @(negedge clk);
        p_wr = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 no irq on same-edge enable", 16'(irq_cnt - base), 16'd0);
        proc_read(2'd2, d, w);
        check("R9 enable and full both set", d, 16'h0005);
        proc_read(2'd0, d, w);
        check("R9 word formed", d, 16'h6677);
        proc_write(2'd2, 16'h0000, w);

        // R10 long-held read strobe acts only on release
        proc_write(2'd1, 16'h9988, w);
        @(negedge clk);
        h_addr = 2'd1; h_cs_n = 1'b0; h_rd_n = 1'b0;
        repeat (20) @(negedge clk);
        proc_read(2'd2, d, w);
        check("R10 held strobe no effect yet", d, 16'h0002);
        check("R10 high byte while held", {8'd0, h_dout}, 16'h0099);
        h_rd_n = 1'b1; h_cs_n = 1'b1;
        repeat (4) @(negedge clk);
        proc_read(2'd2, d, w);
        check("R10 effect after release", d, 16'h0000);
        proc_write(2'd1, 16'h4321, w);
        proc_read(2'd2, d, w);
        check("R10 single effect per access", d, 16'h0002);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule